// File: doc/BRIEF.md
# Transmit Slot Pacing Timer

This block paces the transmit path into fixed-discipline time slots. Each slot carries one data fragment toward the system side and one transmission report. Inside a slot the block steps through a header cycle, one cycle per 32-bit word that is ready to send, a report cycle and a closing tail cycle. If software has programmed a longer minimum, the block then holds the slot open with idle gap cycles. A one-cycle slot-done strobe marks the last cycle of every slot.

The slot length is the largest of three values: the natural length (three overhead cycles plus one per ready word), a hard floor of six cycles, and the programmed minimum when that minimum is non-zero. Writing zero selects the fastest mode, where only the natural length and the six-cycle floor apply. Start requests are latched: a request that arrives during a slot launches the next slot in the cycle after slot-done. The word count and the programmed minimum are both captured when a slot launches.

Top module: `tx_slot_pacer`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata[7:0]` as the programmed minimum. `cfg_rdata[7:0]` returns it from the next cycle on, `cfg_rdata[31:8]` always reads zero, and written upper bits have no effect.
- R2: A start request sampled at a clock edge while the block is idle makes `slot_active` rise after that edge, and `hdr_valid` is high for exactly that first slot cycle (slot cycle 0).
- R3: `data_valid` is high in slot cycles 1..W, where W is `words_ready` sampled at launch. Values above 252 are clamped to 252.
- R4: `rpt_valid` is high for exactly one cycle per slot, in slot cycle W+1. Slot cycle W+2 is a tail cycle in which hdr, data, report and gap outputs are all low.
- R5: The slot lasts L = max(W+3, 6, M) cycles, where M is the programmed minimum and counts only when non-zero. `slot_active` is high for all L cycles and `slot_done` is high only in the last one.
- R6: With M = 0 (fastest mode) no slot is shorter than 6 cycles, even with 0 to 3 ready words.
- R7: Slot cycles W+3..L-1 are gap cycles: `gap_active` is high and `hdr_valid`, `data_valid` and `rpt_valid` are low. At most one of the four phase outputs is high in any cycle.
- R8: A start request during a slot is held and launches the next slot in the cycle directly after `slot_done`, with no idle cycle between the two slots. Several requests during one slot launch only one slot.
- R9: M is captured at launch. A write during a slot changes only the length of later slots.
- R10: A synchronous active-high `rst` returns the block to idle: all outputs are low, any pending request is dropped and M is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the minimum-cycle register |
| cfg_wdata | input | 32 | Write data; only bits 7:0 are stored |
| cfg_rdata | output | 32 | Read data; programmed minimum zero-extended |
| start_req | input | 1 | Request to run a slot (latched if busy) |
| words_ready | input | 9 | Number of 32-bit words ready, sampled at launch |
| slot_active | output | 1 | High during every cycle of a slot |
| hdr_valid | output | 1 | Header phase cycle |
| data_valid | output | 1 | Data word phase cycle |
| rpt_valid | output | 1 | Transmission report cycle |
| gap_active | output | 1 | Idle gap cycle that pads the slot to its minimum |
| slot_done | output | 1 | Strobe in the last cycle of a slot |

## Verification
The bench uses the default parameters: an 8-bit slot counter, an 8-bit minimum field and a 9-bit word-count input. The 9-bit input allows word counts above 252, so the clamp and the 255-cycle ceiling can be exercised. An 8-bit counter keeps even the longest slot short enough for many slots to run back to back. With these widths the bench covers fastest-mode slots at the six-cycle floor, slots padded to a programmed minimum with gap cycles, slots where the data alone exceeds the minimum, and requests queued during a slot.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_DATA,
    PH_RPT,
    PH_TAIL,
    PH_GAP
  } phase_e;
endpackage

// File: rtl/tsp_cfg_reg.sv
module tsp_cfg_reg #(
  parameter int CFG_W = 32,
  parameter int MIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic [MIN_W-1:0] min_q
);
  always_ff @(posedge clk) begin
    if (rst)     min_q <= '0;
    else if (we) min_q <= wdata[MIN_W-1:0];
  end

  assign rdata = CFG_W'(min_q);
endmodule

// File: rtl/tsp_len_calc.sv
module tsp_len_calc #(
  parameter int WORD_W   = 9,
  parameter int CNT_W    = 8,
  parameter int MIN_W    = 8,
  parameter int OVERHEAD = 3,
  parameter int FLOOR    = 6
) (
  input  logic [WORD_W-1:0] words_in,
  input  logic [MIN_W-1:0]  min_in,
  output logic [CNT_W-1:0]  words_eff,
  output logic [CNT_W-1:0]  slot_len
);
  localparam int MAX_WORDS = (1 << CNT_W) - 1 - OVERHEAD;
  localparam int XW        = ((WORD_W > CNT_W) ? WORD_W : CNT_W) + 1;

  logic [XW-1:0] words_x, natural_x, floor_x, min_x;

  assign words_x = XW'(words_in);

  generate
    if (MAX_WORDS >= (1 << WORD_W) - 1) begin : g_no_clamp
      assign words_eff = CNT_W'(words_in);
    end else begin : g_clamp
      assign words_eff = (words_x > XW'(MAX_WORDS)) ? CNT_W'(MAX_WORDS)
                                                    : CNT_W'(words_in);
    end
  endgenerate

  always_comb begin
    natural_x = XW'(words_eff) + XW'(OVERHEAD);
    min_x     = XW'(min_in);
    floor_x   = ((min_in != '0) && (min_x > XW'(FLOOR))) ? min_x : XW'(FLOOR);
    slot_len  = CNT_W'((natural_x > floor_x) ? natural_x : floor_x);
  end
endmodule

// File: rtl/tsp_start_ctl.sv
module tsp_start_ctl (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic slot_free,
  output logic launch
);
  logic pend_q;

  assign launch = (start_req | pend_q) & slot_free;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (pend_q | start_req) & ~launch;
  end
endmodule

// File: rtl/tsp_phase_seq.sv
module tsp_phase_seq
  import tsp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [CNT_W-1:0] words_in,
  input  logic [CNT_W-1:0] len_in,
  output logic             active_o,
  output logic             hdr_o,
  output logic             data_o,
  output logic             rpt_o,
  output logic             gap_o,
  output logic             done_o
);
  localparam logic [CNT_W:0]   ONE_X = (CNT_W+1)'(1);
  localparam logic [CNT_W:0]   TWO_X = (CNT_W+1)'(2);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, nw_q, len_q;
  logic [CNT_W-1:0] cnt_n, nw_n, len_n;
  logic             act_n, done_n;
  logic [CNT_W:0]   c_x, w_x;
  phase_e           ph_n;

  always_comb begin
    act_n = active_o;
    cnt_n = cnt_q;
    nw_n  = nw_q;
    len_n = len_q;
    if (launch) begin
      act_n = 1'b1;
      cnt_n = '0;
      nw_n  = words_in;
      len_n = len_in;
    end else if (active_o && done_o) begin
      act_n = 1'b0;
      cnt_n = '0;
    end else if (active_o) begin
      cnt_n = cnt_q + ONE_C;
    end
  end

  always_comb begin
    c_x = {1'b0, cnt_n};
    w_x = {1'b0, nw_n};
    if (!act_n)               ph_n = PH_IDLE;
    else if (c_x == '0)       ph_n = PH_HDR;
    else if (c_x <= w_x)      ph_n = PH_DATA;
    else if (c_x == w_x + ONE_X) ph_n = PH_RPT;
    else if (c_x == w_x + TWO_X) ph_n = PH_TAIL;
    else                      ph_n = PH_GAP;
    done_n = act_n && (cnt_n == len_n - ONE_C);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      nw_q     <= '0;
      len_q    <= '0;
      active_o <= 1'b0;
      hdr_o    <= 1'b0;
      data_o   <= 1'b0;
      rpt_o    <= 1'b0;
      gap_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      nw_q     <= nw_n;
      len_q    <= len_n;
      active_o <= act_n;
      hdr_o    <= (ph_n == PH_HDR);
      data_o   <= (ph_n == PH_DATA);
      rpt_o    <= (ph_n == PH_RPT);
      gap_o    <= (ph_n == PH_GAP);
      done_o   <= done_n;
    end
  end
endmodule

// File: rtl/tx_slot_pacer.sv
module tx_slot_pacer #(
  parameter int CFG_W    = 32,
  parameter int MIN_W    = 8,
  parameter int CNT_W    = 8,
  parameter int WORD_W   = 9,
  parameter int OVERHEAD = 3,
  parameter int FLOOR    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              start_req,
  input  logic [WORD_W-1:0] words_ready,
  output logic              slot_active,
  output logic              hdr_valid,
  output logic              data_valid,
  output logic              rpt_valid,
  output logic              gap_active,
  output logic              slot_done
);
  logic [MIN_W-1:0] min_q;
  logic [CNT_W-1:0] words_eff, slot_len;
  logic             launch, slot_free;

  assign slot_free = ~slot_active | slot_done;

  tsp_cfg_reg #(.CFG_W(CFG_W), .MIN_W(MIN_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .min_q(min_q)
  );

  tsp_len_calc #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .MIN_W(MIN_W),
    .OVERHEAD(OVERHEAD), .FLOOR(FLOOR)
  ) u_len (
    .words_in(words_ready), .min_in(min_q),
    .words_eff(words_eff), .slot_len(slot_len)
  );

  tsp_start_ctl u_start (
    .clk(clk), .rst(rst), .start_req(start_req),
    .slot_free(slot_free), .launch(launch)
  );

  tsp_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .launch(launch),
    .words_in(words_eff), .len_in(slot_len),
    .active_o(slot_active), .hdr_o(hdr_valid), .data_o(data_valid),
    .rpt_o(rpt_valid), .gap_o(gap_active), .done_o(slot_done)
  );
endmodule

// File: rtl/tsp_checker.sv
module tsp_checker #(
  parameter int CFG_W = 32,
  parameter int MIN_W = 8,
  parameter int CNT_W = 8,
  parameter int FLOOR = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             slot_active,
  input logic             hdr_valid,
  input logic             data_valid,
  input logic             rpt_valid,
  input logic             gap_active,
  input logic             slot_done
);
  logic [CNT_W:0]   len_acc;
  logic [CNT_W-1:0] rpt_acc;

  always_ff @(posedge clk) begin
    if (rst || slot_done) begin
      len_acc <= '0;
      rpt_acc <= '0;
    end else begin
      if (slot_active) len_acc <= len_acc + (CNT_W+1)'(1);
      if (rpt_valid)   rpt_acc <= rpt_acc + CNT_W'(1);
    end
  end

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[CFG_W-1:MIN_W] == '0); // R1
  AST_PHASE_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid || data_valid || rpt_valid || gap_active) |-> slot_active); // R2
  AST_START_WITH_HDR: assert property (@(posedge clk) disable iff (rst)
    $rose(slot_active) |-> hdr_valid); // R2
  AST_ONE_REPORT: assert property (@(posedge clk) disable iff (rst)
    slot_done |-> (rpt_acc == CNT_W'(1))); // R4
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
    (slot_active && !slot_done) |=> slot_active); // R5
  AST_FLOOR_LEN: assert property (@(posedge clk) disable iff (rst)
    slot_done |-> (len_acc >= (CNT_W+1)'(FLOOR - 1))); // R6
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hdr_valid, data_valid, rpt_valid, gap_active})); // R7
  AST_GAP_AFTER_TAIL: assert property (@(posedge clk) disable iff (rst)
    $rose(gap_active) |-> (!$past(data_valid) && !$past(rpt_valid))); // R7
  AST_NEXT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    slot_done |=> (!slot_active || hdr_valid)); // R8
endmodule

bind tx_slot_pacer tsp_checker #(
  .CFG_W(CFG_W), .MIN_W(MIN_W), .CNT_W(CNT_W), .FLOOR(FLOOR)
) u_tsp_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .slot_active(slot_active),
  .hdr_valid(hdr_valid), .data_valid(data_valid), .rpt_valid(rpt_valid),
  .gap_active(gap_active), .slot_done(slot_done)
);

// File: tb/tx_slot_pacer_test.sv
`timescale 1ns/1ps
module tx_slot_pacer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        start_req = 1'b0;
  logic [8:0]  words_ready = '0;
  logic        slot_active, hdr_valid, data_valid, rpt_valid, gap_active, slot_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cur_len = 0;
  int last_len = 0;
  int done_cnt = 0;

  // reference model state
  bit [4:0] exp_q[$];   // {done,gap,rpt,data,hdr}
  bit       m_pend = 0;
  int       m_min = 0;

  always #10 clk = ~clk;

  tx_slot_pacer uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .start_req(start_req), .words_ready(words_ready),
    .slot_active(slot_active), .hdr_valid(hdr_valid), .data_valid(data_valid),
    .rpt_valid(rpt_valid), .gap_active(gap_active), .slot_done(slot_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: queue of per-cycle expectations for each slot
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      exp_q.delete();
      m_pend = 0;
      m_min = 0;
    end else begin
      bit go;
      if (exp_q.size() > 0) void'(exp_q.pop_front());
      go = (start_req || m_pend) && (exp_q.size() == 0);
      if (go) begin
        int w, len;
        w = (words_ready > 252) ? 252 : int'(words_ready);
        len = w + 3;
        if (len < 6) len = 6;
        if (m_min != 0 && m_min > len) len = m_min;
        for (int k = 0; k < len; k++) begin
          bit [4:0] e;
          e[0] = (k == 0);
          e[1] = (k >= 1 && k <= w);
          e[2] = (k == w + 1);
          e[3] = (k >= w + 3);
          e[4] = (k == len - 1);
          exp_q.push_back(e);
        end
      end
      m_pend = (m_pend || start_req) && !go;
      if (cfg_we) m_min = int'(cfg_wdata[7:0]);
    end
  end

  // per-cycle comparison and slot length monitor
  always @(negedge clk) begin
    bit [5:0] act, exp;
    string    tag;
    act = {slot_active, slot_done, gap_active, rpt_valid, data_valid, hdr_valid};
    exp = (exp_q.size() > 0) ? {1'b1, exp_q[0]} : 6'd0;
    if (exp == 0)          tag = "R8";
    else if (exp[0])       tag = "R2";
    else if (exp[1])       tag = "R3";
    else if (exp[3])       tag = "R7";
    else                   tag = "R4";
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d outputs actual=%b expected=%b", tag, cyc, act, exp);
    end
    if (rst) begin
      cur_len = 0;
    end else if (slot_active) begin
      cur_len++;
      if (slot_done) begin
        last_len = cur_len;
        cur_len = 0;
        done_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog R5 actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic [31:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    tick;
    cfg_we = 1'b0;
  endtask

  task automatic start_slot(input int w);
    start_req = 1'b1;
    words_ready = 9'(w);
    tick;
    start_req = 1'b0;
  endtask

  task automatic wait_idle;
    while (slot_active) tick;
  endtask

  task automatic one_slot(input string tag, input int w, input int exp_len);
    start_slot(w);
    wait_idle;
    chk(tag, last_len, exp_len);
  endtask

  initial begin
    tick; tick;
    rst = 1'b0;
    tick;
    // R10: reset state
    chk("R10", int'(slot_active), 0);
    chk("R10", int'(cfg_rdata), 0);

    // R1: only bits 7:0 stored, upper read as zero
    cfg_write(32'hFFFF_FF0A);
    chk("R1", int'(cfg_rdata), 32'h0A);
    cfg_write(32'h0000_0000);
    chk("R1", int'(cfg_rdata), 0);

    // R2 / R6: fastest mode floor
    one_slot("R6", 0, 6);
    one_slot("R6", 3, 6);
    one_slot("R2", 1, 6);
    // R5: natural length beyond floor
    one_slot("R5", 4, 7);
    one_slot("R5", 5, 8);

    // R7: padded slots with gap
    cfg_write(32'd20);
    one_slot("R7", 4, 20);
    one_slot("R7", 0, 20);
    one_slot("R5", 30, 33);
    cfg_write(32'd2);
    one_slot("R5", 0, 6);

    // R3: clamp and ceiling
    cfg_write(32'd0);
    one_slot("R3", 400, 255);
    one_slot("R3", 252, 255);
    cfg_write(32'd255);
    one_slot("R5", 10, 255);

    // R8: requests during a slot collapse into one follow-on slot
    cfg_write(32'd12);
    begin
      int d0;
      d0 = done_cnt;
      start_slot(2);
      tick;
      start_slot(1);
      tick;
      start_slot(6);
      wait_idle;
      tick; tick;
      chk("R8", done_cnt - d0, 2);
    end

    // R8: held request gives back-to-back slots
    start_req = 1'b1;
    words_ready = 9'd3;
    repeat (30) tick;
    start_req = 1'b0;
    wait_idle;

    // R9: minimum captured at launch
    cfg_write(32'd10);
    start_slot(1);
    tick;
    cfg_write(32'd30);
    wait_idle;
    chk("R9", last_len, 10);
    one_slot("R9", 1, 30);

    // mixed sweep, compared every cycle by the model
    for (int i = 0; i < 40; i++) begin
      cfg_write(32'((i * 37) % 64));
      start_slot((i * 13) % 70);
      wait_idle;
    end

    // R10: reset in the middle of a slot clears state and pending request
    cfg_write(32'd40);
    start_slot(5);
    tick;
    start_req = 1'b1;
    tick;
    start_req = 1'b0;
    rst = 1'b1;
    tick; tick;
    rst = 1'b0;
    tick;
    chk("R10", int'(slot_active), 0);
    chk("R10", int'(cfg_rdata), 0);
    tick; tick;
    chk("R10", int'(slot_active), 0);
    one_slot("R10", 0, 6);

    tick;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule